// File: doc/BRIEF.md
# Masked-Access Pin Register Bank

This block is the register side of an 8-pin general-purpose I/O port. It sits behind a simple 32-bit memory-mapped bus with single-cycle read and write strobes and a 12-bit word offset. It holds the pin data, the per-pin direction and a set of configuration bytes. Those configuration bytes are passed unchanged to a separate interrupt-detection block and to pin muxing logic. The block drives an output-enable vector and an output-value vector to the pads, and it samples the pad input vector through a synchronizer.

The lowest kilobyte of the window is one data register seen through a mask. Offset bits [9:2] act as a per-pin enable, for reads as well as for writes. Software can therefore set or clear any subset of output pins with one store and no read-modify-write. A fixed identification ROM sits at the top of the 4 KB window. All other offsets are reserved.

Top module: `pinbank_regs`

## Requirements
- R1: After a synchronous reset, the direction, output and configuration registers and `rd_data` are all zero, so `pin_oe` is zero and every pin is an input.
- R2: A write to any offset below 0x400 changes an output bit only where offset bit [2+k] is 1 and direction bit k is 1, and sets it to `wr_data[k]`. Every other output bit keeps its value.
- R3: A read from any offset below 0x400 returns, in bits [7:0], the pin data view ANDed with offset bits [9:2]. Bits [31:8] read zero.
- R4: For a pin whose direction bit is 0, the data view shows `pin_in` after two clock stages of synchronization. For a pin whose direction bit is 1, the data view shows the output register.
- R5: Six configuration bytes have fixed offsets: direction at 0x400, sense at 0x404, both-edges at 0x408, event at 0x40C, interrupt enable at 0x410 and mode select at 0x420. A write stores `wr_data[7:0]` and drops the upper bits. A read returns the stored byte zero-extended.
- R6: `pin_oe` equals the direction byte, and `pin_out` equals the output register.
- R7: The eight words from 0xFE0 to 0xFFC read, in rising address order, 0x61, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1, each in bits [7:0] with zero above. Writes to these words change nothing.
- R8: Offsets 0x414, 0x418, 0x41C and 0x424 through 0xFDC are reserved. They read as zero, and writes to them change no register and no output.
- R9: `rd_data` is registered. It takes the value for the offset presented with `rd_en` at the next clock edge, and it holds its value in every cycle without `rd_en`.
- R10: `cfg_sense`, `cfg_both`, `cfg_event`, `cfg_irq_en` and `cfg_mode` each equal their configuration byte at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 12 | Byte offset, word aligned (bits [1:0] ignored) |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| pin_in | input | 8 | Asynchronous pad input values |
| pin_oe | output | 8 | Per-pin output enable (1 = drive) |
| pin_out | output | 8 | Per-pin output values |
| cfg_sense | output | 8 | Interrupt sense byte |
| cfg_both | output | 8 | Both-edges byte |
| cfg_event | output | 8 | Event polarity byte |
| cfg_irq_en | output | 8 | Interrupt enable byte |
| cfg_mode | output | 8 | Mode select byte |

## Verification
On every cycle the assertions check four things. A masked data write never disturbs an output bit outside the mask-and-direction set. Writes outside the configuration offsets leave every configuration byte untouched. Reserved and identification reads produce zero in the bits that must be zero. `rd_data` never moves without a read strobe. Only the bench's sweeps can show the exact values: every read mask combined with an asymmetric direction pattern and changing pad inputs, each ROM byte in its position, every reserved word reading zero, and the configuration readback dropping the upper write bits.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

    localparam int ADDR_W    = 12;
    localparam int DATA_W    = 32;
    localparam int NUM_PINS  = 8;
    localparam int NUM_CFG   = 6;
    localparam int CFG_IDX_W = 3;

    typedef enum logic [1:0] {
        REG_NONE = 2'd0,
        REG_DATA = 2'd1,
        REG_CFG  = 2'd2,
        REG_ID   = 2'd3
    } region_e;

    // configuration slot numbering; slot 0 is the direction byte
    typedef enum logic [CFG_IDX_W-1:0] {
        CFG_DIR   = 3'd0,
        CFG_SENSE = 3'd1,
        CFG_BOTH  = 3'd2,
        CFG_EVENT = 3'd3,
        CFG_IEN   = 3'd4,
        CFG_MODE  = 3'd5
    } cfg_e;

    typedef struct packed {
        region_e              region;
        logic [CFG_IDX_W-1:0] cfg_idx;
        logic [2:0]           id_idx;
        logic [7:0]           bitmask;
    } decode_t;

    function automatic decode_t decode_offset(input logic [ADDR_W-1:0] a);
        decode_t d;
        d.region  = REG_NONE;
        d.cfg_idx = '0;
        d.id_idx  = a[4:2];
        d.bitmask = a[9:2];
        if (a[11:10] == 2'b00) begin
            d.region = REG_DATA;
        end else if (a[11:2] >= 10'h3F8) begin
            d.region = REG_ID;
        end else if (a[11:6] == 6'b010000) begin
            d.region = REG_CFG;
            unique case (a[5:2])
                4'h0: d.cfg_idx = CFG_DIR;
                4'h1: d.cfg_idx = CFG_SENSE;
                4'h2: d.cfg_idx = CFG_BOTH;
                4'h3: d.cfg_idx = CFG_EVENT;
                4'h4: d.cfg_idx = CFG_IEN;
                4'h8: d.cfg_idx = CFG_MODE;
                default: d.region = REG_NONE;
            endcase
        end
        return d;
    endfunction

    function automatic logic [7:0] id_byte(input logic [2:0] k);
        logic [7:0] b;
        unique case (k)
            3'd0: b = 8'h61;
            3'd1: b = 8'h10;
            3'd2: b = 8'h14;
            3'd3: b = 8'h00;
            3'd4: b = 8'h0D;
            3'd5: b = 8'hF0;
            3'd6: b = 8'h05;
            default: b = 8'hB1;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[s] <= '0;
                    else     chain_q[s] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[s] <= '0;
                    else     chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/pinbank_cfg.sv
module pinbank_cfg
    import pinbank_pkg::*;
#(
    parameter int PINS = NUM_PINS
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  decode_t                       dec,
    input  logic [DATA_W-1:0]             wr_data,
    output logic [NUM_CFG-1:0][PINS-1:0]  cfg_q
);
    generate
        for (genvar i = 0; i < NUM_CFG; i++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst) begin
                    cfg_q[i] <= '0;
                end else if (wr_en && dec.region == REG_CFG
                             && dec.cfg_idx == CFG_IDX_W'(i)) begin
                    cfg_q[i] <= wr_data[PINS-1:0];
                end
            end
        end
    endgenerate

    // R8 / R7: only configuration offsets may alter the configuration bytes
    assert_cfg_only_by_cfg_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && dec.region != REG_CFG) |=> $stable(cfg_q));

    // R1: reset clears every configuration byte
    assert_cfg_reset_R1: assert property (@(posedge clk)
        rst |=> (cfg_q == '0));
endmodule

// File: rtl/pinbank_data.sv
module pinbank_data
    import pinbank_pkg::*;
#(
    parameter int PINS = NUM_PINS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  decode_t           dec,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PINS-1:0]   dir,
    input  logic [PINS-1:0]   pin_sync,
    output logic [PINS-1:0]   out_q,
    output logic [PINS-1:0]   view
);
    logic [PINS-1:0] wmask;

    assign wmask = dec.bitmask[PINS-1:0] & dir;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else if (wr_en && dec.region == REG_DATA) begin
            out_q <= (out_q & ~wmask) | (wr_data[PINS-1:0] & wmask);
        end
    end

    assign view = (out_q & dir) | (pin_sync & ~dir);

    // R2: bits outside the address mask or set as inputs never change on a data write
    assert_masked_write_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && dec.region == REG_DATA) |=>
        (((out_q ^ $past(out_q)) & ~($past(dec.bitmask[PINS-1:0]) & $past(dir))) == '0));

    // R8: writes outside the data window leave the output register alone
    assert_out_only_by_data_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && dec.region != REG_DATA) |=> $stable(out_q));
endmodule

// File: rtl/pinbank_rdmux.sv
module pinbank_rdmux
    import pinbank_pkg::*;
#(
    parameter int PINS = NUM_PINS
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         rd_en,
    input  decode_t                      dec,
    input  logic [PINS-1:0]              view,
    input  logic [NUM_CFG-1:0][PINS-1:0] cfg_q,
    output logic [DATA_W-1:0]            rd_data
);
    logic [DATA_W-1:0] next_data;

    always_comb begin
        next_data = '0;
        unique case (dec.region)
            REG_DATA: next_data = DATA_W'(view & dec.bitmask[PINS-1:0]);
            REG_CFG:  next_data = DATA_W'(cfg_q[dec.cfg_idx]);
            REG_ID:   next_data = DATA_W'(id_byte(dec.id_idx));
            default:  next_data = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_data <= '0;
        else if (rd_en) rd_data <= next_data;
    end

    // R9: read data only moves on a read strobe
    assert_read_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

    // R8: reserved offsets return zero
    assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && dec.region == REG_NONE) |=> (rd_data == '0));

    // R7: identification words carry one byte only
    assert_id_upper_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && dec.region == REG_ID) |=> (rd_data[DATA_W-1:8] == '0));

    // R3: unmasked data bits read zero
    assert_data_read_masked_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_en && dec.region == REG_DATA) |=>
        ((rd_data & ~DATA_W'($past(dec.bitmask))) == '0));
endmodule

// File: rtl/pinbank_regs.sv
module pinbank_regs
    import pinbank_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [11:0]       addr,
    input  logic [31:0]       wr_data,
    output logic [31:0]       rd_data,
    input  logic [7:0]        pin_in,
    output logic [7:0]        pin_oe,
    output logic [7:0]        pin_out,
    output logic [7:0]        cfg_sense,
    output logic [7:0]        cfg_both,
    output logic [7:0]        cfg_event,
    output logic [7:0]        cfg_irq_en,
    output logic [7:0]        cfg_mode
);
    localparam int PINS = NUM_PINS;

    decode_t                      dec;
    logic [NUM_CFG-1:0][PINS-1:0] cfg_q;
    logic [PINS-1:0]              pin_sync;
    logic [PINS-1:0]              out_q;
    logic [PINS-1:0]              view;

    assign dec = decode_offset(addr);

    pinbank_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    pinbank_cfg #(.PINS(PINS)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .dec     (dec),
        .wr_data (wr_data),
        .cfg_q   (cfg_q)
    );

    pinbank_data #(.PINS(PINS)) u_data (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .dec      (dec),
        .wr_data  (wr_data),
        .dir      (cfg_q[CFG_DIR]),
        .pin_sync (pin_sync),
        .out_q    (out_q),
        .view     (view)
    );

    pinbank_rdmux #(.PINS(PINS)) u_rdmux (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .dec     (dec),
        .view    (view),
        .cfg_q   (cfg_q),
        .rd_data (rd_data)
    );

    assign pin_oe     = cfg_q[CFG_DIR];
    assign pin_out    = out_q;
    assign cfg_sense  = cfg_q[CFG_SENSE];
    assign cfg_both   = cfg_q[CFG_BOTH];
    assign cfg_event  = cfg_q[CFG_EVENT];
    assign cfg_irq_en = cfg_q[CFG_IEN];
    assign cfg_mode   = cfg_q[CFG_MODE];

    // R6: pads are released by reset and only a direction write can enable them
    assert_oe_reset_R6: assert property (@(posedge clk)
        rst |=> (pin_oe == '0 && pin_out == '0));
endmodule

// File: tb/pinbank_regs_bench.sv
module pinbank_regs_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_oe, pin_out;
    logic [7:0]  cfg_sense, cfg_both, cfg_event, cfg_irq_en, cfg_mode;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [7:0] m_cfg [6];
    logic [7:0] m_out;
    logic [11:0] cfg_off [6];
    logic [7:0]  id_exp [8];

    always #5 clk = ~clk;

    pinbank_regs u_pinbank_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .pin_in(pin_in),
        .pin_oe(pin_oe), .pin_out(pin_out), .cfg_sense(cfg_sense),
        .cfg_both(cfg_both), .cfg_event(cfg_event), .cfg_irq_en(cfg_irq_en),
        .cfg_mode(cfg_mode)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    function automatic logic [7:0] view_of(input logic [7:0] inp);
        return (m_out & m_cfg[0]) | (inp & ~m_cfg[0]);
    endfunction

    task automatic check_cfg_outputs(input string req);
        check(req, "pin_oe", {24'h0, pin_oe}, {24'h0, m_cfg[0]});
        check(req, "cfg_sense", {24'h0, cfg_sense}, {24'h0, m_cfg[1]});
        check(req, "cfg_both", {24'h0, cfg_both}, {24'h0, m_cfg[2]});
        check(req, "cfg_event", {24'h0, cfg_event}, {24'h0, m_cfg[3]});
        check(req, "cfg_irq_en", {24'h0, cfg_irq_en}, {24'h0, m_cfg[4]});
        check(req, "cfg_mode", {24'h0, cfg_mode}, {24'h0, m_cfg[5]});
        check(req, "pin_out", {24'h0, pin_out}, {24'h0, m_out});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R9 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [31:0] r0;
        cfg_off[0] = 12'h400; cfg_off[1] = 12'h404; cfg_off[2] = 12'h408;
        cfg_off[3] = 12'h40C; cfg_off[4] = 12'h410; cfg_off[5] = 12'h420;
        id_exp[0] = 8'h61; id_exp[1] = 8'h10; id_exp[2] = 8'h14; id_exp[3] = 8'h00;
        id_exp[4] = 8'h0D; id_exp[5] = 8'hF0; id_exp[6] = 8'h05; id_exp[7] = 8'hB1;
        for (int i = 0; i < 6; i++) m_cfg[i] = '0;
        m_out = '0;

        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1", "rd_data after reset", rd_data, 32'h0);
        check_cfg_outputs("R1");
        for (int i = 0; i < 6; i++) begin
            bus_read(cfg_off[i], r);
            check("R1", "cfg readback after reset", r, 32'h0);
        end

        // R5 / R10: configuration bytes, upper bits dropped
        for (int i = 0; i < 6; i++) begin
            logic [31:0] w;
            w = 32'hC3A5_5A00 ^ (32'h0101_0101 * (i + 1)) ^ 32'(i * 29 + 7);
            m_cfg[i] = w[7:0];
            bus_write(cfg_off[i], w);
        end
        for (int i = 0; i < 6; i++) begin
            bus_read(cfg_off[i], r);
            check("R5", "cfg readback", r, {24'h0, m_cfg[i]});
        end
        check_cfg_outputs("R10");

        // R2 / R3 / R4 / R6: masked data sweep with asymmetric direction
        m_cfg[0] = 8'hA5;
        bus_write(12'h400, 32'hFFFF_FFA5);
        check("R6", "pin_oe follows direction", {24'h0, pin_oe}, 32'h0000_00A5);
        for (int m = 0; m < 256; m++) begin
            logic [7:0] inp, wv, rm, wm;
            inp = 8'(m) ^ 8'h3C;
            wv  = 8'(m * 37) ^ 8'h5A;
            rm  = ~8'(m) ^ 8'(m << 3);
            pin_in = inp;
            bus_write({2'b00, 8'(m), 2'b00}, {24'hFFFFFF, wv});
            wm = 8'(m) & m_cfg[0];
            m_out = (m_out & ~wm) | (wv & wm);
            check("R2", "pin_out after masked write", {24'h0, pin_out}, {24'h0, m_out});
            bus_read({2'b00, rm, 2'b00}, r);
            check("R3", "masked data read", r, {24'h0, view_of(inp) & rm});
        end
        // R4: full-mask read of input pins after a pad change
        pin_in = 8'h5A;
        repeat (3) @(negedge clk);
        bus_read(12'h3FC, r);
        check("R4", "input pins via sync", r, {24'h0, view_of(8'h5A)});

        // R9: registered read, holds without strobe
        bus_read(12'h404, r0);
        @(negedge clk);
        rd_en = 1'b1; addr = 12'hFE0;
        #1;
        check("R9", "rd_data before capture edge", rd_data, r0);
        @(negedge clk);
        rd_en = 1'b0; addr = 12'h408;
        check("R9", "rd_data after capture edge", rd_data, 32'h61);
        repeat (3) @(negedge clk);
        check("R9", "rd_data held without strobe", rd_data, 32'h61);

        // R7: identification words and write immunity
        for (int k = 0; k < 8; k++) bus_write(12'hFE0 + 12'(k * 4), 32'hFFFF_FFFF);
        for (int k = 0; k < 8; k++) begin
            bus_read(12'hFE0 + 12'(k * 4), r);
            check("R7", "id word", r, {24'h0, id_exp[k]});
        end
        check_cfg_outputs("R7");

        // R8: reserved offsets read zero and ignore writes
        for (int a = 12'h414; a <= 12'hFDC; a += 4) begin
            if (a == 12'h420) continue;
            bus_write(12'(a), 32'hFFFF_FFFF);
            bus_read(12'(a), r);
            check("R8", "reserved read", r, 32'h0);
        end
        check_cfg_outputs("R8");
        for (int i = 0; i < 6; i++) begin
            bus_read(cfg_off[i], r);
            check("R8", "cfg intact after reserved writes", r, {24'h0, m_cfg[i]});
        end

        // R1: mid-run reset clears everything again
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 6; i++) m_cfg[i] = '0;
        m_out = '0;
        check("R1", "rd_data after second reset", rd_data, 32'h0);
        check_cfg_outputs("R1");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule